// File: doc/BRIEF.md
# Dual-Order Wrapping Burst Address Generator

This block sits in front of a synchronous cache memory array and turns a start address into the word address of each beat of a four-beat wrapping burst. A burst begins when either of two active-low start strobes is sampled low on a rising clock edge while the chip is selected. One strobe comes from the processor and one from the cache controller. The whole word address is captured on that edge. After that, an active-low advance input steps only the low two address bits. The upper bits stay fixed until the next start.

An order input chooses how the low bits move. When it is high, the order is interleaved: each beat is the start bits XOR the beat number. When it is low, the order is linear: each beat is the start bits plus the beat number, modulo four. The block keeps the start bits and a separate beat count. Because of this, the order input acts at once on the address presented, with no extra cycle. A "selected" flag tells the array whether the last strobe cycle selected the device.

The control is a two-state machine. ST_IDLE means the device is deselected and ST_BURST means a burst is open. Each cycle is decoded into one of four commands:

- CMD_LOAD (strobe with all enables active) moves either state to ST_BURST and captures the address.
- CMD_DROP (strobe with any enable inactive) moves either state to ST_IDLE.
- CMD_STEP (no strobe, advance low) keeps the state and advances the beat.
- CMD_HOLD (no strobe, advance high) keeps the state and suspends the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the selected flag to 0 and the beat count to 0. After reset, addr_out reads 0.
- R2: The chip is selected when cs_a_n = 0, cs_b = 1 and cs_c_n = 0. On an edge where it is selected and either strobe is low (or both are low), all ADDR_W address bits are captured. From the next cycle, addr_out equals the captured address and selected = 1.
- R3: The processor strobe (proc_strb_n) has no effect while cs_a_n = 1. With ctrl_strb_n = 1, such a cycle acts as an ordinary burst-continue cycle. The selected flag is kept, and the beat advances if adv_n = 0.
- R4: A cycle is a deselecting strobe cycle when ctrl_strb_n = 0, or when proc_strb_n = 0 with cs_a_n = 0, while any enable is inactive. On such a cycle, selected goes to 0 on the next cycle and addr_out keeps its value.
- R5: With no strobe acting and adv_n = 0, the beat count steps by one on each edge. Chip enables are not needed for this.
- R6: With no strobe acting and adv_n = 1, addr_out holds its value (burst suspended).
- R7: With order_il = 1, the low two bits of addr_out are start XOR beat. For example, a start of 01 gives 01, 00, 11, 10.
- R8: With order_il = 0, the low two bits of addr_out are (start + beat) mod 4. For example, a start of 11 gives 11, 00, 01, 10.
- R9: Bits [ADDR_W-1:2] of addr_out stay as captured for the whole burst. After four steps, the low bits return to the start value.
- R10: order_il acts combinationally on the captured start and beat. Changing it in the middle of a burst changes addr_out in the same cycle and does not disturb the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_a_n | input | 1 | Chip enable A, active low; also masks the processor strobe |
| cs_b | input | 1 | Chip enable B, active high |
| cs_c_n | input | 1 | Chip enable C, active low |
| proc_strb_n | input | 1 | Processor start strobe, active low |
| ctrl_strb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Advance burst, active low |
| order_il | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Start word address |
| addr_out | output | ADDR_W | Address presented to the array |
| selected | output | 1 | Device selected by the last strobe cycle |

## Verification
The bench builds the block with its default parameters: ADDR_W = 17 and BEAT_W = 2. With these values, every beat of a four-beat wrap can be observed directly at the ports, including the return to the start value. Both orders are exercised from odd start values, where they give different sequences. A change of order in mid-burst at beat one gives different low bits in the two orders, so the combinational order selection can be told apart from a registered one.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_BURST
    } burst_state_e;

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_STEP,
        CMD_LOAD,
        CMD_DROP
    } burst_cmd_e;
endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
    import burst_pkg::*;
(
    input  logic       cs_a_n,
    input  logic       cs_b,
    input  logic       cs_c_n,
    input  logic       proc_strb_n,
    input  logic       ctrl_strb_n,
    input  logic       adv_n,
    output burst_cmd_e cmd
);
    logic chip_en;
    logic proc_act;
    logic ctrl_act;

    always_comb begin
        chip_en  = !cs_a_n && cs_b && !cs_c_n;
        proc_act = !proc_strb_n && !cs_a_n;   // processor strobe masked by enable A
        ctrl_act = !ctrl_strb_n;
        if (proc_act || ctrl_act) begin
            cmd = chip_en ? CMD_LOAD : CMD_DROP;
        end else begin
            cmd = adv_n ? CMD_HOLD : CMD_STEP;
        end
    end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    output logic [BEAT_W-1:0] beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: beat <= '0;
                CMD_STEP: beat <= beat + 1'b1;
                default:  beat <= beat;
            endcase
        end
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_il,
    output logic [BEAT_W-1:0] low
);
    always_comb begin
        if (order_il) begin
            low = start ^ beat;
        end else begin
            low = start + beat;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              cs_c_n,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              selected
);
    localparam int HIGH_W = ADDR_W - BEAT_W;

    burst_cmd_e        cmd;
    burst_state_e      state_q;
    burst_state_e      state_d;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;
    logic [ADDR_W-1:0] base_q;

    burst_strobe_decode u_decode (
        .cs_a_n      (cs_a_n),
        .cs_b        (cs_b),
        .cs_c_n      (cs_c_n),
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .adv_n       (adv_n),
        .cmd         (cmd)
    );

    burst_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .beat (beat)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_order (
        .start    (base_q[BEAT_W-1:0]),
        .beat     (beat),
        .order_il (order_il),
        .low      (low)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd == CMD_LOAD) state_d = ST_BURST;
            ST_BURST: if (cmd == CMD_DROP) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and captured start address
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cmd == CMD_LOAD) begin
                base_q <= addr_in;
            end
        end
    end

    // outputs
    always_comb begin
        selected = (state_q == ST_BURST);
        addr_out = {base_q[ADDR_W-1:BEAT_W], low};
    end

    if (HIGH_W < 1) begin : g_bad_width
        initial $error("ADDR_W must exceed BEAT_W");
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_a_n,
    input logic              cs_b,
    input logic              cs_c_n,
    input logic              proc_strb_n,
    input logic              ctrl_strb_n,
    input logic              adv_n,
    input logic              order_il,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              selected
);
    logic en_all;
    logic strobe;

    assign en_all = !cs_a_n && cs_b && !cs_c_n;
    assign strobe = !ctrl_strb_n || (!proc_strb_n && !cs_a_n);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !selected);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && en_all) |=> (selected && addr_out == $past(addr_in)));

    // R4
    deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !en_all) |=> (!selected && $stable(addr_out)));

    // R6
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!strobe && adv_n && !$isunknown(order_il)) |=>
        ($stable(addr_out) || order_il != $past(order_il)));

    // R9
    high_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R3
    proc_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_a_n && ctrl_strb_n) |=> $stable(selected));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_a_n      (cs_a_n),
    .cs_b        (cs_b),
    .cs_c_n      (cs_c_n),
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .adv_n       (adv_n),
    .order_il    (order_il),
    .addr_in     (addr_in),
    .addr_out    (addr_out),
    .selected    (selected)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int ADDR_W = 17;
    localparam int BEAT_W = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              cs_a_n, cs_b, cs_c_n;
    logic              proc_strb_n, ctrl_strb_n, adv_n, order_il;
    logic [ADDR_W-1:0] addr_in;
    logic [ADDR_W-1:0] addr_out;
    logic              selected;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) dut (
        .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
        .order_il(order_il), .addr_in(addr_in), .addr_out(addr_out),
        .selected(selected)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // wait one edge, then sample a little later
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        cs_a_n = 0; cs_b = 1; cs_c_n = 0;
        proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1;
    endtask

    task automatic start_burst(input logic [ADDR_W-1:0] a, input bit use_proc);
        idle_inputs();
        addr_in = a;
        if (use_proc) proc_strb_n = 0; else ctrl_strb_n = 0;
        tick();
        idle_inputs();
    endtask

    function automatic int expect_addr(input logic [ADDR_W-1:0] a, input int n, input bit il);
        logic [1:0] lo;
        lo = il ? (a[1:0] ^ n[1:0]) : (a[1:0] + n[1:0]);
        return int'({a[ADDR_W-1:2], lo});
    endfunction

    task automatic t_reset();
        rst = 1; idle_inputs(); order_il = 1; addr_in = '1;
        tick(); tick();
        chk("R1 selected", selected, 0);
        chk("R1 addr", addr_out, 0);
        rst = 0;
    endtask

    task automatic t_linear();
        logic [ADDR_W-1:0] a = 17'h1ABCF;
        order_il = 0;
        start_burst(a, 1);
        chk("R2 selected", selected, 1);
        chk("R2 addr", addr_out, a);
        for (int n = 1; n <= 4; n++) begin
            adv_n = 0; tick();
            chk("R8 linear beat", addr_out, expect_addr(a, n, 0));
        end
        chk("R9 wrap to start", addr_out, a);
    endtask

    task automatic t_interleave();
        logic [ADDR_W-1:0] a = 17'h05551;
        order_il = 1;
        start_burst(a, 0);
        chk("R2 ctrl strobe addr", addr_out, a);
        for (int n = 1; n <= 3; n++) begin
            adv_n = 0;
            cs_b = n[0];   // R5: enables not needed to continue
            tick();
            chk("R7 interleave beat", addr_out, expect_addr(a, n, 1));
            chk("R9 high bits fixed", int'(addr_out[ADDR_W-1:2]), int'(a[ADDR_W-1:2]));
        end
        idle_inputs();
    endtask

    task automatic t_suspend();
        logic [ADDR_W-1:0] a = 17'h00002;
        order_il = 0;
        start_burst(a, 1);
        adv_n = 0; tick();
        adv_n = 1; tick(); tick();
        chk("R6 suspend hold", addr_out, expect_addr(a, 1, 0));
        adv_n = 0; tick();
        chk("R5 resume step", addr_out, expect_addr(a, 2, 0));
        adv_n = 1;
    endtask

    task automatic t_proc_masked();
        logic [ADDR_W-1:0] a = 17'h12340;
        order_il = 0;
        start_burst(a, 1);
        cs_a_n = 1; proc_strb_n = 0; adv_n = 0; addr_in = 17'h0FFFF;
        tick();
        chk("R3 still selected", selected, 1);
        chk("R3 continue not load", addr_out, expect_addr(a, 1, 0));
        idle_inputs();
    endtask

    task automatic t_deselect();
        logic [ADDR_W-1:0] hold;
        start_burst(17'h0AAA1, 1);
        hold = addr_out;
        cs_b = 0; ctrl_strb_n = 0; addr_in = 17'h1FFFF;
        tick();
        chk("R4 deselect flag", selected, 0);
        chk("R4 addr held", addr_out, hold);
        start_burst(17'h00010, 1);
        cs_a_n = 1; ctrl_strb_n = 0;
        tick();
        chk("R4 ctrl with enable A off", selected, 0);
        idle_inputs();
    endtask

    task automatic t_both_strobes();
        logic [ADDR_W-1:0] a = 17'h13573;
        idle_inputs();
        addr_in = a; proc_strb_n = 0; ctrl_strb_n = 0;
        tick();
        idle_inputs();
        chk("R2 both strobes load", addr_out, a);
    endtask

    task automatic t_mode_switch();
        logic [ADDR_W-1:0] a = 17'h00101;
        order_il = 1;
        start_burst(a, 1);
        adv_n = 0; tick(); adv_n = 1;
        chk("R10 interleave beat1", addr_out, expect_addr(a, 1, 1));
        order_il = 0; #1;
        chk("R10 same-cycle linear", addr_out, expect_addr(a, 1, 0));
        adv_n = 0; tick(); adv_n = 1;
        chk("R10 beat kept", addr_out, expect_addr(a, 2, 0));
    endtask

    initial begin
        t_reset();
        t_linear();
        t_interleave();
        t_suspend();
        t_proc_masked();
        t_deselect();
        t_both_strobes();
        t_mode_switch();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule